// File: doc/BRIEF.md
# Six-Step Brushless Commutation Sequencer

This block walks a three-phase half-bridge through the six states of trapezoidal brushless motor drive. Each accepted advance request moves it to the next state of a fixed rotation. For every phase it outputs a two-bit role code to the PWM stage downstream. A phase is either switched by the PWM carrier, held with its low-side switch on, or left floating with both switches off.

After reset no state has been entered yet. All three phases are floating, so every high-side switch is held off. The first accepted advance selects state 0. After state 5 the sequence returns to state 0.

A new state is completed by a one-cycle commutation strobe. The downstream stage uses this strobe to load all three role codes together, so the six bridge outputs change on the same clock. The control logic raises the advance request whenever the next state is due. When the enable input is low, advance requests are ignored.

Top module: `sixstep_commutator`

## Requirements
- R1: During reset and after it, until the first accepted advance, `step_idx` reads 7 (the idle marker), all three role codes are 2'b00 (floating) and `com_strobe` is 0.
- R2: An advance is accepted when `en` and `adv` are both high at a rising clock edge. The first accepted advance after reset sets `step_idx` to 0 at that same edge.
- R3: Each further accepted advance raises `step_idx` by one at the sampling edge. From 5 it goes back to 0.
- R4: Role codes are 2'b00 floating, 2'b01 low-side on and 2'b10 PWM. The code 2'b11 never appears. Listed as (PWM, low-on, floating), the states are: 0 = (A, B, C), 1 = (A, C, B), 2 = (B, C, A), 3 = (B, A, C), 4 = (C, A, B), 5 = (C, B, A).
- R5: In every state 0 to 5, exactly one phase carries the PWM code, exactly one carries the low-on code and exactly one is floating.
- R6: `com_strobe` is high for exactly one cycle per accepted advance. It rises at the clock edge after the edge where `step_idx` changed. Back-to-back advances give back-to-back strobe cycles.
- R7: When `en` is low at an edge, the `adv` value at that edge has no effect. `step_idx` holds, and `com_strobe` stays low in the cycle that advance would have strobed.
- R8: Between two successive states 0 to 5, exactly one of these two roles stays with the same phase: PWM or low-on. As a result, each phase holds PWM for two consecutive states and low-on for two consecutive states.
- R9: A synchronous active-high `rst` at any point returns the block to the idle state of R1 at that edge. It also drops any strobe that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows advance requests to be accepted |
| adv | input | 1 | Advance request, sampled each rising edge |
| step_idx | output | 3 | Current state 0..5, or 7 while idle |
| role_a | output | 2 | Role code for phase A |
| role_b | output | 2 | Role code for phase B |
| role_c | output | 2 | Role code for phase C |
| com_strobe | output | 1 | One-cycle commutation strobe |

## Verification
The bench builds the block with its default parameters: three phases, six states and a three-bit state index. At this size every state, every wrap from 5 to 0 and every pairing of `en` and `adv` are reached many times within a few hundred cycles. A reference model derives the next state arithmetically and looks up the role table. It checks every output on every cycle. The stimulus includes single advances, back-to-back advances, advances held off by a low enable, and resets applied both mid-rotation and while a strobe is pending.

// File: rtl/sixstep_pkg.sv
`timescale 1ns/1ps
package sixstep_pkg;

    localparam int NUM_STEPS  = 6;
    localparam int NUM_PHASES = 3;
    localparam int STEP_W     = $clog2(NUM_STEPS + 1);
    localparam int ROLE_W     = 2;

    typedef logic [STEP_W-1:0] step_t;
    localparam step_t IDLE_STEP = '1;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_FLOAT = 2'b00,
        ROLE_LOW   = 2'b01,
        ROLE_PWM   = 2'b10
    } role_e;

    typedef logic [NUM_PHASES-1:0][ROLE_W-1:0] bridge_cfg_t;

    // Phase that receives the PWM carrier: two states per phase.
    function automatic int pwm_phase(input step_t s);
        return int'(s) / 2;
    endfunction

    // Phase held low: follows the PWM phase, shifted by one state.
    function automatic int low_phase(input step_t s);
        return ((int'(s) + 1) / 2 + 1) % NUM_PHASES;
    endfunction

    function automatic logic step_valid(input step_t s);
        return int'(s) < NUM_STEPS;
    endfunction

    // Next state in the rotation; idle and the last state both lead to 0.
    function automatic step_t next_step(input step_t s);
        if (int'(s) >= NUM_STEPS - 1)
            return '0;
        return s + step_t'(1);
    endfunction

endpackage

// File: rtl/sixstep_step_ctr.sv
`timescale 1ns/1ps
module sixstep_step_ctr
    import sixstep_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  adv,
    output step_t step_q,
    output logic  taken_q
);

    logic take;
    assign take = en & adv;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= IDLE_STEP;
            taken_q <= 1'b0;
        end else begin
            taken_q <= take;
            if (take)
                step_q <= next_step(step_q);
        end
    end

endmodule

// File: rtl/sixstep_role_map.sv
`timescale 1ns/1ps
module sixstep_role_map
    import sixstep_pkg::*;
(
    input  step_t       step,
    output bridge_cfg_t cfg
);

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
        always_comb begin
            if (!step_valid(step))
                cfg[g] = ROLE_FLOAT;
            else if (pwm_phase(step) == g)
                cfg[g] = ROLE_PWM;
            else if (low_phase(step) == g)
                cfg[g] = ROLE_LOW;
            else
                cfg[g] = ROLE_FLOAT;
        end
    end

endmodule

// File: rtl/sixstep_strobe_gen.sv
`timescale 1ns/1ps
module sixstep_strobe_gen (
    input  logic clk,
    input  logic rst,
    input  logic taken,
    output logic strobe_q
);

    always_ff @(posedge clk) begin
        if (rst)
            strobe_q <= 1'b0;
        else
            strobe_q <= taken;
    end

endmodule

// File: rtl/sixstep_commutator.sv
`timescale 1ns/1ps
module sixstep_commutator
    import sixstep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              adv,
    output logic [STEP_W-1:0] step_idx,
    output logic [ROLE_W-1:0] role_a,
    output logic [ROLE_W-1:0] role_b,
    output logic [ROLE_W-1:0] role_c,
    output logic              com_strobe
);

    step_t       cur_step;
    logic        taken;
    bridge_cfg_t cfg;

    sixstep_step_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .adv     (adv),
        .step_q  (cur_step),
        .taken_q (taken)
    );

    sixstep_role_map u_map (
        .step (cur_step),
        .cfg  (cfg)
    );

    sixstep_strobe_gen u_stb (
        .clk      (clk),
        .rst      (rst),
        .taken    (taken),
        .strobe_q (com_strobe)
    );

    assign step_idx = cur_step;
    assign role_a   = cfg[0];
    assign role_b   = cfg[1];
    assign role_c   = cfg[2];

endmodule

// File: rtl/sixstep_commutator_chk.sv
`timescale 1ns/1ps
module sixstep_commutator_chk
    import sixstep_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              adv,
    input logic [STEP_W-1:0] step_idx,
    input logic [ROLE_W-1:0] role_a,
    input logic [ROLE_W-1:0] role_b,
    input logic [ROLE_W-1:0] role_c,
    input logic              com_strobe
);

    logic [2:0]        pwm_m, low_m, rsv_m;
    logic [2:0]        prev_pwm, prev_low;
    logic [STEP_W-1:0] prev_step;
    logic              prev_rst;
    logic              chg;

    assign pwm_m = {role_c == 2'b10, role_b == 2'b10, role_a == 2'b10};
    assign low_m = {role_c == 2'b01, role_b == 2'b01, role_a == 2'b01};
    assign rsv_m = {role_c == 2'b11, role_b == 2'b11, role_a == 2'b11};
    assign chg   = step_idx != prev_step;

    always_ff @(posedge clk) begin
        prev_rst <= rst;
        if (rst) begin
            prev_step <= IDLE_STEP;
            prev_pwm  <= '0;
            prev_low  <= '0;
        end else begin
            prev_step <= step_idx;
            prev_pwm  <= pwm_m;
            prev_low  <= low_m;
        end
    end

    AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (rst)
        step_idx == IDLE_STEP |-> (pwm_m == 3'b000 && low_m == 3'b000 && rsv_m == 3'b000)); // R1

    AST_FIRST_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (chg && !prev_rst && prev_step == IDLE_STEP) |-> step_idx == '0); // R2

    AST_ROTATE: assert property (@(posedge clk) disable iff (rst)
        (chg && !prev_rst && prev_step != IDLE_STEP) |->
            step_idx == ((prev_step == STEP_W'(NUM_STEPS - 1)) ? '0 : prev_step + 1'b1)); // R3

    AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (rst)
        rsv_m == 3'b000); // R4

    AST_ONE_EACH: assert property (@(posedge clk) disable iff (rst)
        step_idx != IDLE_STEP |-> ($countones(pwm_m) == 1 && $countones(low_m) == 1 && (pwm_m & low_m) == 3'b000)); // R5

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (chg && !prev_rst) |=> com_strobe); // R6

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        com_strobe |-> $past(chg)); // R6

    AST_EN_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(step_idx)); // R7

    AST_EN_LOW_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !en |=> ##1 !com_strobe); // R7

    AST_ROLE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        (chg && !prev_rst && prev_step != IDLE_STEP) |-> ((pwm_m == prev_pwm) != (low_m == prev_low))); // R8

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        prev_rst |-> (step_idx == IDLE_STEP && !com_strobe)); // R9

endmodule

bind sixstep_commutator sixstep_commutator_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .adv        (adv),
    .step_idx   (step_idx),
    .role_a     (role_a),
    .role_b     (role_b),
    .role_c     (role_c),
    .com_strobe (com_strobe)
);

// File: tb/sixstep_commutator_tb.sv
`timescale 1ns/1ps
module sixstep_commutator_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       adv = 1'b0;
    logic [2:0] step_idx;
    logic [1:0] role_a, role_b, role_c;
    logic       com_strobe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model state
    int m_step = 7;
    bit m_taken = 0;
    bit m_strobe = 0;
    int prev_m_step = 7;

    always #2.5 clk = ~clk;

    sixstep_commutator u_dut (
        .clk(clk), .rst(rst), .en(en), .adv(adv),
        .step_idx(step_idx), .role_a(role_a), .role_b(role_b), .role_c(role_c),
        .com_strobe(com_strobe)
    );

    // expected {a,b,c}: 00 float, 01 low, 10 pwm
    function automatic logic [5:0] exp_roles(input int s);
        case (s)
            0: return {2'b10, 2'b01, 2'b00};
            1: return {2'b10, 2'b00, 2'b01};
            2: return {2'b00, 2'b10, 2'b01};
            3: return {2'b01, 2'b10, 2'b00};
            4: return {2'b01, 2'b00, 2'b10};
            5: return {2'b00, 2'b01, 2'b10};
            default: return 6'b000000;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [5:0] er;
        logic [5:0] ar;
        int npwm, nlow;
        er = exp_roles(m_step);
        ar = {role_a, role_b, role_c};
        check("R3 step_idx", int'(step_idx), m_step);
        check("R4 roles", int'(ar), int'(er));
        check("R6 com_strobe", int'(com_strobe), int'(m_strobe));
        if (m_step != 7) begin
            npwm = 0; nlow = 0;
            for (int p = 0; p < 3; p++) begin
                if (ar[2*p +: 2] == 2'b10) npwm++;
                if (ar[2*p +: 2] == 2'b01) nlow++;
            end
            check("R5 one pwm", npwm, 1);
            check("R5 one low", nlow, 1);
        end
        if (m_step != prev_m_step && prev_m_step != 7 && m_step != 7) begin
            logic [5:0] pr;
            bit same_pwm, same_low;
            pr = exp_roles(prev_m_step);
            same_pwm = 1; same_low = 1;
            for (int p = 0; p < 3; p++) begin
                if ((ar[2*p +: 2] == 2'b10) != (pr[2*p +: 2] == 2'b10)) same_pwm = 0;
                if ((ar[2*p +: 2] == 2'b01) != (pr[2*p +: 2] == 2'b01)) same_low = 0;
            end
            check("R8 one role kept", int'(same_pwm ^ same_low), 1);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, update model, compare
    task automatic cyc(input bit r, input bit e, input bit a);
        rst = r; en = e; adv = a;
        @(negedge clk);
        prev_m_step = m_step;
        if (r) begin
            m_step = 7; m_taken = 0; m_strobe = 0;
        end else begin
            m_strobe = m_taken;
            m_taken  = e && a;
            if (e && a) m_step = (m_step >= 5) ? 0 : m_step + 1;
        end
        compare_all();
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(1, 0, 0);
        cyc(1, 1, 1);
        // R1: idle state after reset
        cyc(0, 0, 0);
        check("R1 idle step", int'(step_idx), 7);
        check("R1 idle roles", int'({role_a, role_b, role_c}), 0);
        check("R1 idle strobe", int'(com_strobe), 0);
        cyc(0, 1, 0);
        check("R1 no adv keeps idle", int'(step_idx), 7);

        // R2: first accepted advance enters state 0
        cyc(0, 1, 1);
        check("R2 first entry", int'(step_idx), 0);
        cyc(0, 1, 0);
        check("R6 strobe one cycle later", int'(com_strobe), 1);
        cyc(0, 1, 0);
        check("R6 strobe single cycle", int'(com_strobe), 0);

        // R3/R4/R6: back-to-back advances over two full rotations
        for (int i = 0; i < 13; i++) cyc(0, 1, 1);
        cyc(0, 1, 0);
        cyc(0, 1, 0);

        // R7: enable low, advance held high
        begin
            int held;
            held = int'(step_idx);
            for (int i = 0; i < 4; i++) cyc(0, 0, 1);
            check("R7 step held with en low", int'(step_idx), held);
            check("R7 no strobe with en low", int'(com_strobe), 0);
        end

        // mixed pattern sweep
        for (int i = 0; i < 120; i++)
            cyc(0, (i % 7) != 3, (i % 3) != 2);

        // R9: reset mid-rotation with a strobe pending
        cyc(0, 1, 1);
        cyc(1, 1, 1);
        check("R9 reset to idle", int'(step_idx), 7);
        check("R9 pending strobe dropped", int'(com_strobe), 0);
        cyc(0, 0, 0);
        check("R9 strobe still low", int'(com_strobe), 0);
        cyc(0, 1, 1);
        check("R2 entry after reset", int'(step_idx), 0);

        // sweep with isolated advances to exercise every state
        for (int i = 0; i < 40; i++)
            cyc(0, 1, (i % 4) == 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule